// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits between a command queue and an 8-bit parallel NOR flash device. Each queued entry carries an operation code, a 24-bit address and a data byte. When the sequencer is idle and the queue is not empty, it takes exactly one entry. It then expands the entry into the series of bus writes the flash needs to unlock and enter the requested mode. It drives the chip-enable, write-strobe, output-enable and reset pins with setup, strobe-width, hold and access times counted in clocks.

A program ends with a wait on the flash ready/busy line. While the flash is busy, later entries stay in the queue. A read ends with a single read strobe, and the captured byte is handed back together with a one-cycle valid pulse. A reset sequence returns the flash to read mode. The ready wait is bounded by a timeout that raises a sticky error flag and lets the sequencer go back to idle.

Top module: `nor_cmd_seq`

## Requirements
- R1: While `rst_n` is low, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are high, `fl_dq_oe`, `rd_valid`, `err_timeout` and `fl_rst_n` are low. After reset is released, `fl_rst_n` goes high.
- R2: `cmd_pop` is asserted only while the sequencer is idle and `cmd_empty` is low, and never while a bus cycle is active. Each pop of a recognised code starts exactly one sequence, and the next pop waits until that sequence has ended.
- R3: Code 0x01 (program) produces four bus writes, in this order: address 0xAAA with data 0xAA, address 0x555 with 0x55, address 0xAAA with 0xA0, then the command address with the command data.
- R4: Code 0x02 (read) produces one bus write of 0xF0 to address 0. It is followed by a read cycle at the command address, and the byte on `fl_dq_in` at the end of the access time is returned on `rd_data`.
- R5: Code 0x03 (reset) produces three bus writes: 0xAAA/0xAA, then 0x555/0x55, then address 0 with 0xF0.
- R6: In every bus write, `fl_ce_n` is low and `fl_dq_oe` is high at least one clock before `fl_we_n` falls. `fl_we_n` stays low for exactly `T_PULSE` clocks, with `fl_ce_n` low, `fl_oe_n` high, and address and data stable throughout.
- R7: In a read cycle, `fl_ce_n` and `fl_oe_n` are low for exactly `T_ACC` clocks with `fl_we_n` high. `rd_valid` pulses for one clock in the cycle after `fl_oe_n` rises.
- R8: `fl_dq_oe` is high only inside a write cycle, never while `fl_oe_n` is low and never while `fl_ce_n` is high.
- R9: After the last program write, no command is taken until `fl_ready` is seen high again.
- R10: If `fl_ready` stays low for `BUSY_TIMEOUT` clocks during the program wait, `err_timeout` is set and the sequencer returns to idle. `err_timeout` then stays set until reset.
- R11: An entry whose code is not 0x01, 0x02 or 0x03 is popped and dropped without any bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_empty | input | 1 | Command queue has no entry |
| cmd_code | input | 8 | Operation code at queue head |
| cmd_addr | input | ADDR_W | Address at queue head |
| cmd_data | input | 8 | Data byte at queue head |
| cmd_pop | output | 1 | Takes the head entry this clock |
| fl_addr | output | ADDR_W | Flash address bus |
| fl_dq_out | output | 8 | Flash data bus, outgoing value |
| fl_dq_oe | output | 1 | Drive enable for the flash data bus |
| fl_dq_in | input | 8 | Flash data bus, incoming value |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write strobe, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_rst_n | output | 1 | Flash reset, active low |
| fl_ready | input | 1 | Flash ready (high) / busy (low) |
| rd_data | output | 8 | Byte returned by a read |
| rd_valid | output | 1 | One-clock pulse when rd_data is new |
| err_timeout | output | 1 | Sticky program-wait timeout flag |

## Verification
The bench builds the block with `T_SETUP`=2, `T_PULSE`=3, `T_HOLD`=2, `T_ACC`=4, `BUSY_TIMEOUT`=40 and the two-stage ready synchroniser enabled. Strobe widths and access times longer than one clock make an off-by-one in any timed phase visible. The short timeout lets a flash model that never leaves busy drive the error path, and the bench checks both that the flag stays clear before the limit and that it is set after it. A back-to-back program and read, with a busy time longer than the synchroniser delay, shows that the second entry waits in the queue and reads back the freshly programmed byte.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

   localparam logic [7:0] CODE_PROG = 8'h01;
   localparam logic [7:0] CODE_READ = 8'h02;
   localparam logic [7:0] CODE_RST  = 8'h03;

   typedef enum logic [1:0] {
      K_NONE = 2'd0,
      K_PROG = 2'd1,
      K_READ = 2'd2,
      K_RST  = 2'd3
   } op_kind_e;

   // one-hot so each strobe is a single flop bit
   typedef enum logic [7:0] {
      S_IDLE  = 8'h01,
      S_WSET  = 8'h02,
      S_WPUL  = 8'h04,
      S_WHLD  = 8'h08,
      S_WREC  = 8'h10,
      S_RACC  = 8'h20,
      S_RDONE = 8'h40,
      S_BUSY  = 8'h80
   } seq_st_e;

   function automatic op_kind_e decode_op(input logic [7:0] code);
      case (code)
         CODE_PROG: decode_op = K_PROG;
         CODE_READ: decode_op = K_READ;
         CODE_RST:  decode_op = K_RST;
         default:   decode_op = K_NONE;
      endcase
   endfunction

   function automatic logic [1:0] final_step(input op_kind_e k);
      case (k)
         K_PROG:  final_step = 2'd3;
         K_RST:   final_step = 2'd2;
         default: final_step = 2'd0;
      endcase
   endfunction

   // {addr[11:0], data[7:0]} of a fixed unlock write
   function automatic logic [19:0] unlock_pair(input op_kind_e k, input logic [1:0] i);
      logic [19:0] r;
      r = {12'h000, 8'hF0};
      if (k == K_PROG || k == K_RST) begin
         case (i)
            2'd0:    r = {12'hAAA, 8'hAA};
            2'd1:    r = {12'h555, 8'h55};
            2'd2:    r = (k == K_PROG) ? {12'hAAA, 8'hA0} : {12'h000, 8'hF0};
            default: r = {12'h000, 8'h00};
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/nor_seq_step.sv
module nor_seq_step
   import nor_seq_pkg::*;
#(
   parameter int ADDR_W = 24
)(
   input  op_kind_e          kind,
   input  logic [1:0]        idx,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [7:0]        op_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [7:0]        bus_data,
   output logic              is_last
);
   localparam int PAT_W = 12;

   logic [19:0]       pat;
   logic [ADDR_W-1:0] pat_addr;
   logic              use_op;

   assign pat    = unlock_pair(kind, idx);
   assign use_op = (kind == K_PROG) && (idx == 2'd3);

   generate
      if (ADDR_W == PAT_W) begin : g_exact
         assign pat_addr = pat[19:8];
      end else begin : g_pad
         assign pat_addr = {{(ADDR_W-PAT_W){1'b0}}, pat[19:8]};
      end
   endgenerate

   assign bus_addr = use_op ? op_addr : pat_addr;
   assign bus_data = use_op ? op_data : pat[7:0];
   assign is_last  = (idx == final_step(kind));
endmodule

// File: rtl/nor_seq_timer.sv
module nor_seq_timer #(
   parameter int CNT_W = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= load_val;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);
endmodule

// File: rtl/nor_seq_busy_mon.sv
module nor_seq_busy_mon #(
   parameter int LIMIT = 1000
)(
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic run,
   input  logic ready,
   output logic expire
);
   localparam int W = $clog2(LIMIT + 1);
   localparam logic [W-1:0] LAST = W'(LIMIT - 1);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              cnt <= '0;
      else if (clear)                          cnt <= '0;
      else if (run && !ready && cnt != LAST)   cnt <= cnt + 1'b1;
   end

   assign expire = run && !ready && (cnt == LAST);
endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_seq_pkg::*;
#(
   parameter int ADDR_W       = 24,
   parameter int T_SETUP      = 1,
   parameter int T_PULSE      = 2,
   parameter int T_HOLD       = 1,
   parameter int T_ACC        = 3,
   parameter int BUSY_TIMEOUT = 100000,
   parameter bit SYNC_READY   = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_empty,
   input  logic [7:0]        cmd_code,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [7:0]        cmd_data,
   output logic              cmd_pop,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [7:0]        fl_dq_out,
   output logic              fl_dq_oe,
   input  logic [7:0]        fl_dq_in,
   output logic              fl_ce_n,
   output logic              fl_we_n,
   output logic              fl_oe_n,
   output logic              fl_rst_n,
   input  logic              fl_ready,
   output logic [7:0]        rd_data,
   output logic              rd_valid,
   output logic              err_timeout
);
   localparam int TMAX_A = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
   localparam int TMAX_B = (T_HOLD  > T_ACC)   ? T_HOLD  : T_ACC;
   localparam int TMAX   = (TMAX_A  > TMAX_B)  ? TMAX_A  : TMAX_B;
   localparam int CNT_W  = $clog2(TMAX + 1);
   localparam logic [CNT_W-1:0] LD_SET = CNT_W'(T_SETUP - 1);
   localparam logic [CNT_W-1:0] LD_PUL = CNT_W'(T_PULSE - 1);
   localparam logic [CNT_W-1:0] LD_HLD = CNT_W'(T_HOLD - 1);
   localparam logic [CNT_W-1:0] LD_ACC = CNT_W'(T_ACC - 1);

   generate
      if (ADDR_W < 12)       begin : g_bad_addr  $error("ADDR_W must cover the unlock addresses"); end
      if (T_SETUP < 1)       begin : g_bad_set   $error("T_SETUP must be at least 1"); end
      if (T_PULSE < 1)       begin : g_bad_pul   $error("T_PULSE must be at least 1"); end
      if (T_HOLD < 1)        begin : g_bad_hld   $error("T_HOLD must be at least 1"); end
      if (T_ACC < 1)         begin : g_bad_acc   $error("T_ACC must be at least 1"); end
      if (BUSY_TIMEOUT < 1)  begin : g_bad_to    $error("BUSY_TIMEOUT must be at least 1"); end
   endgenerate

   seq_st_e           st, nxt;
   op_kind_e          kind_q, dec_kind;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        data_q;
   logic [1:0]        idx_q;
   logic [7:0]        rd_q;
   logic              err_q, rstout_q;

   logic              take, step_clr, step_inc, cap, err_set, bw_clear;
   logic              tmr_load, tmr_done;
   logic [CNT_W-1:0]  tmr_val;
   logic [ADDR_W-1:0] step_addr;
   logic [7:0]        step_data;
   logic              step_last;
   logic              ready_s, bw_expire;
   logic              in_write;

   // ready/busy line: optional two-stage synchroniser
   generate
      if (SYNC_READY) begin : g_sync
         logic [1:0] rdy_ff;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdy_ff <= 2'b11;
            else        rdy_ff <= {rdy_ff[0], fl_ready};
         end
         assign ready_s = rdy_ff[1];
      end else begin : g_direct
         assign ready_s = fl_ready;
      end
   endgenerate

   assign dec_kind = decode_op(cmd_code);

   nor_seq_step #(.ADDR_W(ADDR_W)) u_step (
      .kind     (kind_q),
      .idx      (idx_q),
      .op_addr  (addr_q),
      .op_data  (data_q),
      .bus_addr (step_addr),
      .bus_data (step_data),
      .is_last  (step_last)
   );

   nor_seq_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   nor_seq_busy_mon #(.LIMIT(BUSY_TIMEOUT)) u_bmon (
      .clk    (clk),
      .rst_n  (rst_n),
      .clear  (bw_clear),
      .run    (st == S_BUSY),
      .ready  (ready_s),
      .expire (bw_expire)
   );

   always_comb begin
      nxt      = st;
      take     = 1'b0;
      step_clr = 1'b0;
      step_inc = 1'b0;
      cap      = 1'b0;
      err_set  = 1'b0;
      bw_clear = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (st)
         S_IDLE: begin
            if (!cmd_empty) begin
               take = 1'b1;
               if (dec_kind != K_NONE) begin
                  nxt      = S_WSET;
                  step_clr = 1'b1;
                  tmr_load = 1'b1;
                  tmr_val  = LD_SET;
               end
            end
         end
         S_WSET: if (tmr_done) begin
            nxt = S_WPUL; tmr_load = 1'b1; tmr_val = LD_PUL;
         end
         S_WPUL: if (tmr_done) begin
            nxt = S_WHLD; tmr_load = 1'b1; tmr_val = LD_HLD;
         end
         S_WHLD: if (tmr_done) nxt = S_WREC;
         S_WREC: begin
            if (!step_last) begin
               step_inc = 1'b1;
               nxt      = S_WSET;
               tmr_load = 1'b1;
               tmr_val  = LD_SET;
            end else begin
               case (kind_q)
                  K_PROG: begin nxt = S_BUSY; bw_clear = 1'b1; end
                  K_READ: begin nxt = S_RACC; tmr_load = 1'b1; tmr_val = LD_ACC; end
                  default: nxt = S_IDLE;
               endcase
            end
         end
         S_RACC: if (tmr_done) begin
            cap = 1'b1; nxt = S_RDONE;
         end
         S_RDONE: nxt = S_IDLE;
         S_BUSY: begin
            if (ready_s) nxt = S_IDLE;
            else if (bw_expire) begin
               err_set = 1'b1;
               nxt     = S_IDLE;
            end
         end
         default: nxt = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         kind_q   <= K_NONE;
         addr_q   <= '0;
         data_q   <= '0;
         idx_q    <= '0;
         rd_q     <= '0;
         err_q    <= 1'b0;
         rstout_q <= 1'b0;
      end else begin
         st       <= nxt;
         rstout_q <= 1'b1;
         if (take) begin
            kind_q <= dec_kind;
            addr_q <= cmd_addr;
            data_q <= cmd_data;
         end
         if (step_clr)      idx_q <= '0;
         else if (step_inc) idx_q <= idx_q + 1'b1;
         if (cap)           rd_q  <= fl_dq_in;
         if (err_set)       err_q <= 1'b1;
      end
   end

   assign in_write    = (st == S_WSET) || (st == S_WPUL) || (st == S_WHLD);
   assign cmd_pop     = take;
   assign fl_we_n     = (st != S_WPUL);
   assign fl_oe_n     = (st != S_RACC);
   assign fl_ce_n     = !(in_write || (st == S_RACC));
   assign fl_dq_oe    = in_write;
   assign fl_dq_out   = in_write ? step_data : 8'h00;
   assign fl_addr     = in_write ? step_addr : ((st == S_RACC) ? addr_q : '0);
   assign fl_rst_n    = rstout_q;
   assign rd_data     = rd_q;
   assign rd_valid    = (st == S_RDONE);
   assign err_timeout = err_q;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
   parameter int ADDR_W  = 24,
   parameter int T_PULSE = 2,
   parameter int T_ACC   = 3
)(
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_empty,
   input logic              cmd_pop,
   input logic [ADDR_W-1:0] fl_addr,
   input logic [7:0]        fl_dq_out,
   input logic              fl_dq_oe,
   input logic              fl_ce_n,
   input logic              fl_we_n,
   input logic              fl_oe_n,
   input logic              fl_rst_n,
   input logic              rd_valid,
   input logic              err_timeout
);
   int unsigned we_low, oe_low;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_low <= 0;
         oe_low <= 0;
      end else begin
         we_low <= fl_we_n ? 0 : we_low + 1;
         oe_low <= fl_oe_n ? 0 : oe_low + 1;
      end
   end

   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && !fl_rst_n && !rd_valid && !err_timeout));

   p_pop_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pop |-> (!cmd_empty && fl_ce_n && fl_we_n && fl_oe_n));

   p_we_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_we_n |-> (!fl_ce_n && fl_oe_n && fl_dq_oe));

   p_we_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fl_we_n) |-> $past(!fl_ce_n && fl_dq_oe));

   p_we_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out)));

   p_we_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_we_n) |-> (we_low == T_PULSE));

   p_oe_frame_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !fl_oe_n |-> (!fl_ce_n && fl_we_n));

   p_oe_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fl_oe_n) |-> ((oe_low == T_ACC) && rd_valid));

   p_rdv_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid);

   p_dq_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fl_dq_oe |-> (!fl_ce_n && fl_oe_n));

   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_timeout |=> err_timeout);
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(
   .ADDR_W  (ADDR_W),
   .T_PULSE (T_PULSE),
   .T_ACC   (T_ACC)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cmd_empty   (cmd_empty),
   .cmd_pop     (cmd_pop),
   .fl_addr     (fl_addr),
   .fl_dq_out   (fl_dq_out),
   .fl_dq_oe    (fl_dq_oe),
   .fl_ce_n     (fl_ce_n),
   .fl_we_n     (fl_we_n),
   .fl_oe_n     (fl_oe_n),
   .fl_rst_n    (fl_rst_n),
   .rd_valid    (rd_valid),
   .err_timeout (err_timeout)
);

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb;
   localparam int ADDR_W   = 24;
   localparam int T_SETUP  = 2;
   localparam int T_PULSE  = 3;
   localparam int T_HOLD   = 2;
   localparam int T_ACC    = 4;
   localparam int TIMEOUT  = 40;
   localparam int BUSY_CYC = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cmd_empty = 1'b1;
   logic [7:0]        cmd_code = '0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [7:0]        cmd_data = '0;
   logic              cmd_pop;
   logic [ADDR_W-1:0] fl_addr;
   logic [7:0]        fl_dq_out, fl_dq_in, rd_data;
   logic              fl_dq_oe, fl_ce_n, fl_we_n, fl_oe_n, fl_rst_n, fl_ready;
   logic              rd_valid, err_timeout;

   always #2.5 clk = ~clk;

   nor_cmd_seq #(
      .ADDR_W(ADDR_W), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD),
      .T_ACC(T_ACC), .BUSY_TIMEOUT(TIMEOUT), .SYNC_READY(1'b1)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_empty(cmd_empty), .cmd_code(cmd_code),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_pop(cmd_pop),
      .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe),
      .fl_dq_in(fl_dq_in), .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n),
      .fl_oe_n(fl_oe_n), .fl_rst_n(fl_rst_n), .fl_ready(fl_ready),
      .rd_data(rd_data), .rd_valid(rd_valid), .err_timeout(err_timeout)
   );

   // ---------------- command queue (show-ahead) ----------------
   logic [39:0] cq[$];
   bit          pend = 1'b0;
   int          pops = 0;

   always @(negedge clk) begin
      if (pend) begin
         void'(cq.pop_front());
         pops++;
         pend = 1'b0;
      end
      cmd_empty = (cq.size() == 0);
      if (cq.size() > 0) {cmd_code, cmd_addr, cmd_data} = cq[0];
      #1 pend = cmd_pop;
   end

   // ---------------- behavioural flash model ----------------
   logic [7:0]  mem [256];
   logic [31:0] wlog[$];
   logic [7:0]  rlog[$];
   int          busy_left = 0;
   bit          hang = 1'b0;
   bit          armed = 1'b0;
   logic        prev_we = 1'b1, prev_oe = 1'b1;
   logic [31:0] h0 = '0, h1 = '0, h2 = '0;
   int          wcnt = 0, ocnt = 0;
   bit          dq_clash = 1'b0;
   int          m_checks = 0, m_fails = 0, r9_viol = 0;

   initial for (int i = 0; i < 256; i++) mem[i] = 8'hFF;

   assign fl_ready = (busy_left == 0);
   assign fl_dq_in = fl_oe_n ? 8'h5A : mem[fl_addr[7:0]];

   always @(negedge clk) if (rst_n) begin
      logic [31:0] e;
      if (!prev_we && fl_we_n) begin
         e = {fl_addr, fl_dq_out};
         wlog.push_back(e);
         if (armed) begin
            mem[fl_addr[7:0]] = fl_dq_out;
            armed = 1'b0;
            busy_left = BUSY_CYC;
            h0 = '0; h1 = '0; h2 = '0;
         end else begin
            h0 = h1; h1 = h2; h2 = e;
            if (h0 == {24'hAAA, 8'hAA} && h1 == {24'h555, 8'h55} && h2 == {24'hAAA, 8'hA0})
               armed = 1'b1;
         end
         m_checks++;
         if (wcnt != T_PULSE) begin
            m_fails++;
            $display("FAIL R6 write strobe width act=%0d exp=%0d", wcnt, T_PULSE);
         end
      end
      if (!prev_oe && fl_oe_n) begin
         m_checks++;
         if (ocnt != T_ACC || dq_clash) begin
            m_fails++;
            $display("FAIL R7/R8 read strobe width act=%0d exp=%0d driver_clash=%0d", ocnt, T_ACC, dq_clash);
         end
         dq_clash = 1'b0;
      end
      if (!fl_oe_n && fl_dq_oe) dq_clash = 1'b1;
      wcnt = fl_we_n ? 0 : wcnt + 1;
      ocnt = fl_oe_n ? 0 : ocnt + 1;
      if (rd_valid) rlog.push_back(rd_data);
      if (cmd_pop && !fl_ready) r9_viol++;
      if (busy_left > 0 && !hang) busy_left--;
      prev_we = fl_we_n;
      prev_oe = fl_oe_n;
   end

   // ---------------- checking helpers ----------------
   int  tests = 0, fails = 0;

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s act=0x%0h exp=0x%0h", req, what, act, exp);
      end
   endtask

   task automatic cmp_writes(input string req, input logic [31:0] exp[$]);
      check(wlog.size() == exp.size(), req, "write count", wlog.size(), exp.size());
      foreach (exp[i]) begin
         if (i < wlog.size())
            check(wlog[i] == exp[i], req, $sformatf("write %0d addr/data", i), wlog[i], exp[i]);
      end
      wlog.delete();
   endtask

   task automatic push(input logic [7:0] c, input logic [23:0] a, input logic [7:0] d);
      cq.push_back({c, a, d});
   endtask

   task automatic settle(input int extra);
      for (int i = 0; i < 2000 && (cq.size() != 0 || pend); i++) @(negedge clk);
      repeat (extra) @(negedge clk);
   endtask

   task automatic finish_run(input int add_fail);
      $display("[TB] %0d tests run, %0d failed", tests + m_checks + add_fail, fails + m_fails + add_fail);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog expired act=hung exp=done");
      finish_run(1);
   end

   // ---------------- stimulus ----------------
   initial begin
      logic [31:0] ew[$];
      int p0;
      repeat (3) @(negedge clk);
      // R1: quiet pins during reset
      check(fl_ce_n && fl_we_n && fl_oe_n, "R1", "strobes high in reset", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
      check(!fl_dq_oe && !rd_valid && !err_timeout, "R1", "oe/valid/err low in reset",
            {fl_dq_oe, rd_valid, err_timeout}, 0);
      check(!fl_rst_n && !cmd_pop, "R1", "flash reset asserted, no pop", {fl_rst_n, cmd_pop}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(fl_rst_n, "R1", "flash reset released", fl_rst_n, 1);

      // R3: program
      push(8'h01, 24'h000012, 8'h3C);
      settle(60);
      ew = '{{24'hAAA, 8'hAA}, {24'h555, 8'h55}, {24'hAAA, 8'hA0}, {24'h000012, 8'h3C}};
      cmp_writes("R3", ew);
      check(!err_timeout, "R10", "no error after normal program", err_timeout, 0);

      // R4: read back the programmed byte
      push(8'h02, 24'h000012, 8'h00);
      settle(40);
      ew = '{{24'h000000, 8'hF0}};
      cmp_writes("R4", ew);
      check(rlog.size() == 1, "R7", "one valid pulse per read", rlog.size(), 1);
      if (rlog.size() > 0) check(rlog[0] == 8'h3C, "R4", "read data", rlog[0], 8'h3C);
      rlog.delete();

      // R5: reset sequence
      push(8'h03, 24'h123456, 8'h99);
      settle(40);
      ew = '{{24'hAAA, 8'hAA}, {24'h555, 8'h55}, {24'h000000, 8'hF0}};
      cmp_writes("R5", ew);

      // R11: unknown code dropped, following entry still served
      p0 = pops;
      push(8'h07, 24'h000020, 8'h11);
      push(8'h03, 24'h000000, 8'h00);
      settle(40);
      ew = '{{24'hAAA, 8'hAA}, {24'h555, 8'h55}, {24'h000000, 8'hF0}};
      cmp_writes("R11", ew);
      check(pops - p0 == 2, "R2", "one pop per entry", pops - p0, 2);
      check(rlog.size() == 0, "R11", "no read data from dropped code", rlog.size(), 0);

      // R9: program then read queued back to back
      push(8'h01, 24'h000040, 8'hC3);
      push(8'h02, 24'h000040, 8'h00);
      settle(60);
      ew = '{{24'hAAA, 8'hAA}, {24'h555, 8'h55}, {24'hAAA, 8'hA0}, {24'h000040, 8'hC3},
             {24'h000000, 8'hF0}};
      cmp_writes("R9", ew);
      check(r9_viol == 0, "R9", "no pop while flash busy", r9_viol, 0);
      check(rlog.size() == 1 && rlog[0] == 8'hC3, "R9", "read after busy sees new byte",
            rlog.size() > 0 ? rlog[0] : 0, 8'hC3);
      rlog.delete();

      // R4: unwritten location
      push(8'h02, 24'h000077, 8'h00);
      settle(40);
      wlog.delete();
      check(rlog.size() == 1 && rlog[0] == 8'hFF, "R4", "erased location reads FF",
            rlog.size() > 0 ? rlog[0] : 0, 8'hFF);
      rlog.delete();

      // R10: flash never leaves busy
      hang = 1'b1;
      push(8'h01, 24'h000005, 8'h11);
      for (int i = 0; i < 500 && wlog.size() < 4; i++) @(negedge clk);
      repeat (20) @(negedge clk);
      check(!err_timeout, "R10", "flag clear before limit", err_timeout, 0);
      repeat (60) @(negedge clk);
      check(err_timeout, "R10", "flag set after limit", err_timeout, 1);
      hang = 1'b0;
      wlog.delete();
      repeat (20) @(negedge clk);
      push(8'h02, 24'h000005, 8'h00);
      settle(40);
      check(rlog.size() == 1 && rlog[0] == 8'h11, "R10", "idle again after timeout",
            rlog.size() > 0 ? rlog[0] : 0, 8'h11);
      check(err_timeout, "R10", "flag stays set", err_timeout, 1);
      check(r9_viol == 0, "R9", "no pop while busy over whole run", r9_viol, 0);

      finish_run(0);
   end
endmodule